// File: doc/BRIEF.md
# I2C Register Target with Auto-Incrementing Pointer

This block sits on a two-wire I2C bus as a target and lets a bus host reach an 8-byte register file. It oversamples SCL and SDA on a fast system clock, recognises START, repeated START and STOP, and matches a fixed 7-bit device address. It supports three transaction types. In a write, the first byte after the address sets the register pointer and each further byte is stored. In a random read, the pointer is set, a repeated START follows, and bytes are returned. In a current-address read, bytes are returned from wherever the pointer was last left.

The register pointer is volatile. On a read it advances only when the host acknowledges a byte, and it wraps from the last register back to 0. On a write it advances once the acknowledge clock of a stored byte completes. SDA is open-drain: `sda_oe` high means the block pulls the line low.

On the register side, the block presents a byte address, read data that comes back combinationally from that address, and a write port. The write port has a valid strobe and no ready. The bus has no way to wait, so the register file must accept every strobe in the cycle it is raised. A read-active flag tells the register file that a host read of the time registers is in progress, so that it can hold back its own updates until the read ends.

Top module: `i2c_regport`

## Requirements
- R1: The block acknowledges (pulls SDA low during the ninth clock) an address byte whose upper seven bits equal 1101000. Bit 0 of that byte selects the direction: 0 means write (byte D0h) and 1 means read (byte D1h).
- R2: An address byte with any other upper seven bits is not acknowledged. After it, the block neither drives SDA nor strobes a write until the next START.
- R3: In a write, the byte after the address loads its low three bits into the pointer and produces no write strobe. Each later byte raises `reg_wvalid` for exactly one cycle, with `reg_wdata` equal to the byte and `reg_addr` equal to the pointer. The pointer then advances by one. The block acknowledges every one of these bytes.
- R4: In a random read, the host writes the word address, issues a repeated START with byte D1h, and then receives the contents of that register, MSB first, followed by the contents of the registers after it.
- R5: During a read, the pointer advances only when the host acknowledges a byte. After a host NACK, the block releases SDA and stays released until the next START.
- R6: A read with no pointer write begins at the pointer value left by the previous transfer, including a write that carried only a word address.
- R7: The pointer wraps from 7 to 0, on both writes and reads.
- R8: `rd_active` rises at the address acknowledge of a read when the pointer is 0 to 6, or later in the same read when the pointer moves into 0 to 6. It stays low while only register 7 is being read, and it falls on a STOP or a host NACK.
- R9: A STOP returns the block to idle with SDA released. A START or repeated START at any point restarts address reception, and the pointer is kept across these conditions.
- R10: `sda_oe` changes only while SCL is low.
- R11: After reset, `sda_oe`, `reg_wvalid` and `rd_active` are 0 and `reg_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be many times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | AW (3) | Register index, equal to the pointer |
| reg_wdata | output | 8 | Byte to be written |
| reg_wvalid | output | 1 | One-cycle write strobe, no back-pressure |
| reg_rdata | input | 8 | Contents of register `reg_addr`, combinational |
| rd_active | output | 1 | A host read of registers 0 to 6 is in progress |

## Verification
The hardest case to reach from the ports is a read that passes through register 7. Here `rd_active` must stay low while register 7 goes out, and must rise only after the host acknowledge carries the pointer around to 0. At the same time the next byte has to be fetched from the freshly advanced address before its first bit is put on SDA. The stimulus reaches this case in two ways: directed reads that start at pointer 7 with one and then two bytes, and random reads whose start pointer and length are drawn so that many of them cross the wrap. A bench-side copy of the register contents and of the pointer predicts every returned byte and every level of the flag. The bench also tests whether a rejected address leaves the pointer untouched, by issuing a current-address read after it.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_WR_BYTE,
    S_WR_ACK,
    S_RD_LOAD,
    S_RD_BYTE,
    S_RD_ACK
  } tgt_state_e;

endpackage

// File: rtl/i2c_line_cond.sv
// Synchronises the two bus lines and derives clock edges and bus conditions.
module i2c_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_chain, sda_chain;
  logic scl_q, sda_q, scl_s;

  // Lines idle high, so the chain resets to ones and no edge appears at reset release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_i};
      sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
      scl_q     <= scl_chain[SYNC_STAGES-1];
      sda_q     <= sda_chain[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_chain[SYNC_STAGES-1];
  assign sda_s     = sda_chain[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_reg_ptr.sv
// Volatile register pointer with load and wrapping increment.
module i2c_reg_ptr #(
  parameter int REG_COUNT = 8,
  localparam int AW = $clog2(REG_COUNT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] ptr
);

  logic [AW-1:0] ptr_next_inc;

  generate
    if ((REG_COUNT & (REG_COUNT - 1)) == 0) begin : g_pow2
      assign ptr_next_inc = ptr + 1'b1;
    end else begin : g_cmp
      assign ptr_next_inc = (ptr == AW'(REG_COUNT - 1)) ? '0 : ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= load_val;
    end else if (inc) begin
      ptr <= ptr_next_inc;
    end
  end

endmodule

// File: rtl/i2c_tgt_fsm.sv
// Byte engine and transaction sequencer for the bus target.
module i2c_tgt_fsm
  import i2c_regport_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h68,
  parameter int         REG_COUNT = 8,
  localparam int        AW        = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [AW-1:0]     ptr,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              ptr_load,
  output logic [AW-1:0]     ptr_load_val,
  output logic              ptr_inc,
  output logic              reg_wvalid,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              sda_oe,
  output logic              rd_active,
  output logic              idle
);

  tgt_state_e        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              rw_read;
  logic              first_wr;
  logic              host_ack;
  logic              byte_done;
  logic              last_addr;

  assign byte_done    = scl_fall && (bit_cnt == CNT_W'(BYTE_W));
  assign last_addr    = (ptr == AW'(REG_COUNT - 1));
  assign ptr_load     = (state == S_WR_BYTE) && byte_done && first_wr;
  assign ptr_load_val = shreg[AW-1:0];
  assign ptr_inc      = scl_fall && (((state == S_WR_ACK) && !first_wr) ||
                                     ((state == S_RD_ACK) && host_ack));
  assign idle         = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      rw_read    <= 1'b0;
      first_wr   <= 1'b0;
      host_ack   <= 1'b0;
      sda_oe     <= 1'b0;
      reg_wvalid <= 1'b0;
      reg_wdata  <= '0;
      rd_active  <= 1'b0;
    end else begin
      reg_wvalid <= 1'b0;
      if (stop_det) begin
        state     <= S_IDLE;
        sda_oe    <= 1'b0;
        rd_active <= 1'b0;
      end else if (start_det) begin
        state   <= S_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else begin
        case (state)
          S_ADDR: begin
            if (scl_rise) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (byte_done) begin
              if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                state   <= S_ADDR_ACK;
                sda_oe  <= 1'b1;
                rw_read <= shreg[0];
                if (shreg[0] && !last_addr) rd_active <= 1'b1;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_ADDR_ACK: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              if (rw_read) begin
                state <= S_RD_LOAD;
              end else begin
                state    <= S_WR_BYTE;
                first_wr <= 1'b1;
              end
            end
          end
          S_WR_BYTE: begin
            if (scl_rise) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (byte_done) begin
              state   <= S_WR_ACK;
              sda_oe  <= 1'b1;
              bit_cnt <= '0;
              if (!first_wr) begin
                reg_wvalid <= 1'b1;
                reg_wdata  <= shreg;
              end
            end
          end
          S_WR_ACK: begin
            if (scl_fall) begin
              sda_oe   <= 1'b0;
              first_wr <= 1'b0;
              state    <= S_WR_BYTE;
            end
          end
          S_RD_LOAD: begin
            shreg   <= reg_rdata;
            sda_oe  <= ~reg_rdata[BYTE_W-1];
            bit_cnt <= '0;
            state   <= S_RD_BYTE;
            if (!last_addr) rd_active <= 1'b1;
          end
          S_RD_BYTE: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall) begin
              if (bit_cnt == CNT_W'(BYTE_W)) begin
                state  <= S_RD_ACK;
                sda_oe <= 1'b0;
              end else begin
                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~shreg[BYTE_W-2];
              end
            end
          end
          S_RD_ACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (host_ack) begin
                state <= S_RD_LOAD;
              end else begin
                state     <= S_IDLE;
                rd_active <= 1'b0;
              end
            end
          end
          default: begin
            state <= S_IDLE;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_regport.sv
// Top level: I2C target giving a host access to a small register file.
module i2c_regport #(
  parameter int         REG_COUNT   = 8,
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         SYNC_STAGES = 2,
  localparam int        AW          = $clog2(REG_COUNT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  output logic          reg_wvalid,
  input  logic [7:0]    reg_rdata,
  output logic          rd_active
);

  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          ptr_load, ptr_inc, tgt_idle;
  logic [AW-1:0] ptr_load_val, ptr;

  i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_reg_ptr #(.REG_COUNT(REG_COUNT)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (ptr_load_val),
    .inc      (ptr_inc),
    .ptr      (ptr)
  );

  i2c_tgt_fsm #(.DEV_ADDR(DEV_ADDR), .REG_COUNT(REG_COUNT)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sda_s        (sda_s),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .ptr          (ptr),
    .reg_rdata    (reg_rdata),
    .ptr_load     (ptr_load),
    .ptr_load_val (ptr_load_val),
    .ptr_inc      (ptr_inc),
    .reg_wvalid   (reg_wvalid),
    .reg_wdata    (reg_wdata),
    .sda_oe       (sda_oe),
    .rd_active    (rd_active),
    .idle         (tgt_idle)
  );

  assign reg_addr = ptr;

endmodule

// File: rtl/i2c_regport_chk.sv
// Temporal checks for the register target, attached by bind.
module i2c_regport_chk #(
  parameter int REG_COUNT = 8,
  localparam int AW = $clog2(REG_COUNT)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_oe,
  input logic          reg_wvalid,
  input logic [AW-1:0] reg_addr,
  input logic          rd_active,
  input logic          tgt_idle
);

  // R10: the data line driver only moves while the bus clock is low
  a_r10_oe_moves_scl_low : assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R3: a write strobe lasts a single cycle
  a_r3_strobe_single : assert property (@(posedge clk) disable iff (!rst_n)
    reg_wvalid |=> !reg_wvalid);

  // R3: the pointer holds still around a write strobe
  a_r3_strobe_addr_stable : assert property (@(posedge clk) disable iff (!rst_n)
    reg_wvalid |-> $stable(reg_addr));

  // R8: the read flag never rises while the last register is addressed
  a_r8_flag_not_on_last : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_active) |-> (reg_addr != AW'(REG_COUNT - 1)));

  // R2, R9: an idle target leaves the data line alone
  a_r9_idle_released : assert property (@(posedge clk) disable iff (!rst_n)
    tgt_idle |-> !sda_oe);

endmodule

bind i2c_regport i2c_regport_chk #(.REG_COUNT(REG_COUNT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_i      (scl_i),
  .sda_oe     (sda_oe),
  .reg_wvalid (reg_wvalid),
  .reg_addr   (reg_addr),
  .rd_active  (rd_active),
  .tgt_idle   (tgt_idle)
);

// File: tb/test_i2c_regport.sv
module test_i2c_regport;

  localparam int Q = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n    = 1'b0;
  logic       host_scl = 1'b1;
  logic       host_sda = 1'b1;
  logic       sda_line;
  logic       sda_oe, reg_wvalid, rd_active;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  assign sda_line = host_sda & ~sda_oe;

  i2c_regport i_i2c_regport (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (host_scl),
    .sda_i      (sda_line),
    .sda_oe     (sda_oe),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_wvalid (reg_wvalid),
    .reg_rdata  (reg_rdata),
    .rd_active  (rd_active)
  );

  // Register file attached to the block's port, plus a strobe monitor.
  logic [7:0] rf [8];
  int         wr_count;
  logic [2:0] last_waddr;
  logic [7:0] last_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) rf[i] <= '0;
      wr_count   <= 0;
      last_waddr <= '0;
      last_wdata <= '0;
    end else if (reg_wvalid) begin
      rf[reg_addr] <= reg_wdata;
      wr_count     <= wr_count + 1;
      last_waddr   <= reg_addr;
      last_wdata   <= reg_wdata;
    end
  end
  assign reg_rdata = rf[reg_addr];

  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;
  bit   r10_bad = 1'b0;
  logic prev_oe = 1'b0;

  logic [7:0] exp_rf [8];
  int         exp_ptr;
  logic [7:0] dbuf [16];

  always @(negedge clk) begin
    if (rst_n && (sda_oe != prev_oe) && host_scl) r10_bad = 1'b1;
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; cyc(Q);
    host_scl = 1'b1; cyc(Q);
    host_sda = 1'b0; cyc(Q);
    host_scl = 1'b0; cyc(Q);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; cyc(Q);
    host_scl = 1'b1; cyc(Q);
    host_sda = 1'b1; cyc(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; cyc(Q);
      host_scl = 1'b1; cyc(Q);
      host_scl = 1'b0; cyc(Q);
    end
    host_sda = 1'b1; cyc(Q);
    host_scl = 1'b1; cyc(Q / 2);
    acked = ~sda_line;
    cyc(Q / 2);
    host_scl = 1'b0; cyc(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b, output logic ra);
    host_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      cyc(Q);
      host_scl = 1'b1; cyc(Q / 2);
      b[i] = sda_line;
      if (i == 4) ra = rd_active;
      cyc(Q / 2);
      host_scl = 1'b0;
    end
    cyc(2);
    host_sda = ~give_ack; cyc(Q);
    host_scl = 1'b1; cyc(Q);
    host_scl = 1'b0; cyc(2);
    host_sda = 1'b1; cyc(Q);
  endtask

  task automatic do_write(input logic [2:0] p, input int n);
    logic a;
    int   wc0;
    bus_start();
    send_byte(8'hD0, a);
    chk(a, "R1 write address ack", a, 1);
    send_byte({5'b0, p}, a);
    chk(a, "R3 word address ack", a, 1);
    exp_ptr = p;
    wc0 = wr_count;
    for (int k = 0; k < n; k++) begin
      send_byte(dbuf[k], a);
      chk(a, "R3 data byte ack", a, 1);
      exp_rf[exp_ptr] = dbuf[k];
      exp_ptr = (exp_ptr + 1) % 8;
    end
    bus_stop();
    chk(wr_count - wc0 == n, "R3 write strobe count", wr_count - wc0, n);
    if (n > 0) begin
      chk(last_wdata == dbuf[n-1], "R3 last written data", last_wdata, dbuf[n-1]);
      chk(int'(last_waddr) == (exp_ptr + 7) % 8, "R7 last write address", last_waddr, (exp_ptr + 7) % 8);
    end
  endtask

  task automatic do_read(input bit set_ptr, input logic [2:0] p, input int n);
    logic       a, ra, exp_ra;
    logic [7:0] b;
    bus_start();
    if (set_ptr) begin
      send_byte(8'hD0, a);
      chk(a, "R4 pointer write address ack", a, 1);
      send_byte({5'b0, p}, a);
      chk(a, "R4 pointer byte ack", a, 1);
      exp_ptr = p;
      bus_start();
    end
    send_byte(8'hD1, a);
    chk(a, "R1 R9 read address ack", a, 1);
    exp_ra = (exp_ptr != 7);
    chk(rd_active == exp_ra, "R8 flag after address ack", rd_active, exp_ra);
    for (int k = 0; k < n; k++) begin
      exp_ra = exp_ra | (exp_ptr != 7);
      recv_byte(k != n - 1, b, ra);
      chk(b == exp_rf[exp_ptr], set_ptr ? "R4 random read data" : "R6 current read data",
          b, exp_rf[exp_ptr]);
      chk(ra == exp_ra, "R8 flag during byte", ra, exp_ra);
      if (k != n - 1) exp_ptr = (exp_ptr + 1) % 8;
    end
    chk(!sda_oe, "R5 SDA released after NACK", sda_oe, 0);
    chk(!rd_active, "R8 flag cleared by NACK", rd_active, 0);
    bus_stop();
  endtask

  task automatic do_bad(input logic rw);
    logic [6:0] ad;
    logic       a;
    int         wc0;
    do ad = 7'($urandom); while (ad == 7'h68);
    wc0 = wr_count;
    bus_start();
    send_byte({ad, rw}, a);
    chk(!a, "R2 foreign address not acked", a, 0);
    send_byte(8'($urandom), a);
    chk(!a, "R2 idle until next START", a, 0);
    bus_stop();
    chk(wr_count == wc0, "R2 no write strobe", wr_count, wc0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic a;
    for (int i = 0; i < 8; i++) exp_rf[i] = 8'h00;
    exp_ptr = 0;
    void'($urandom(32'd5150));
    cyc(5);
    rst_n = 1'b1;
    cyc(3);
    // R11: reset state
    chk(!sda_oe, "R11 sda_oe after reset", sda_oe, 0);
    chk(!reg_wvalid, "R11 reg_wvalid after reset", reg_wvalid, 0);
    chk(!rd_active, "R11 rd_active after reset", rd_active, 0);
    chk(reg_addr == 3'd0, "R11 reg_addr after reset", reg_addr, 0);

    // R3 R7: fill all eight registers starting at 0, pointer wraps back to 0
    for (int k = 0; k < 8; k++) dbuf[k] = 8'h11 * (k + 1) ^ 8'hA5;
    do_write(3'd0, 8);
    chk(reg_addr == 3'd0, "R7 pointer wrapped after full write", reg_addr, 0);
    // R7: write wrap from 6
    dbuf[0] = 8'h3C; dbuf[1] = 8'hC3; dbuf[2] = 8'h00; dbuf[3] = 8'hFF;
    do_write(3'd6, 4);
    // R4 R7: random read crossing the wrap
    do_read(1'b1, 3'd5, 5);
    // R6: current-address read continues
    do_read(1'b0, 3'd0, 2);
    // R8: read at register 7 only, flag stays low
    do_read(1'b1, 3'd7, 1);
    // R8: from 7 with ack, flag rises once the pointer wraps
    do_read(1'b0, 3'd0, 2);
    // R2: foreign addresses, both directions, then pointer unchanged
    do_bad(1'b0);
    do_bad(1'b1);
    do_read(1'b0, 3'd0, 1);
    // R6 R9: write carrying only a word address, then STOP, then current read
    bus_start();
    send_byte(8'hD0, a);
    chk(a, "R1 address ack before STOP", a, 1);
    send_byte(8'h03, a);
    chk(a, "R3 word address ack before STOP", a, 1);
    exp_ptr = 3;
    bus_stop();
    chk(!sda_oe, "R9 released after STOP", sda_oe, 0);
    do_read(1'b0, 3'd0, 3);

    for (int it = 0; it < 25; it++) begin
      int         kind, n;
      logic [2:0] p;
      kind = $urandom_range(0, 3);
      n    = $urandom_range(1, 5);
      p    = 3'($urandom_range(0, 7));
      for (int k = 0; k < 8; k++) dbuf[k] = 8'($urandom);
      case (kind)
        0:       do_write(p, n);
        1:       do_read(1'b1, p, n);
        2:       do_read(1'b0, 3'd0, n);
        default: do_bad(1'($urandom));
      endcase
    end

    chk(!r10_bad, "R10 sda_oe changed with SCL high", r10_bad, 0);
    finish_run();
  end

endmodule